// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms the address of a single operand access for a 16-bit processor that uses segmented memory. It takes the current contents of the four segment registers, the two base registers, the two index registers, the instruction pointer and a displacement from the instruction. A 3-bit mode code chooses how these are combined into a 16-bit offset within a segment. The block then forms the 20-bit physical address by shifting the chosen segment value left by four bits and adding the offset. The mode and the registers that form the offset decide which segment register is used. No separate segment select input exists.

The datapath is combinational. An optional output register (`REG_OUT`, on by default) adds one cycle of latency so that the block can sit at a pipeline boundary. A reserved mode code drives both addresses to zero and raises an error flag. The decoder that drives the mode code and the register selects sits outside this block. The same applies to the bus that consumes the address.

Top module: `sag_addr_gen`

## Requirements
- R1: `pa` equals (segment value × 16) + `ea`, taken modulo 2^20. For example, segment 89ABh with offset F012h gives 98AC2h, and segment FFFFh with offset FFFFh wraps to 0FFEFh.
- R2: Mode code 0 (direct) uses all 16 bits of `disp` as `ea` and ignores `disp_wide`. The segment is `seg_ds`.
- R3: Mode code 1 (register indirect) takes `ea` from the register picked by `ptr_sel`: 0 = `reg_bx`, 1 = `reg_bp`, 2 = `reg_si`, 3 = `reg_di`. The segment is always `seg_ds`, including when `reg_bp` is picked.
- R4: In modes 2, 3 and 4, when `disp_wide` = 0, only `disp[7:0]` is used and it is sign-extended to 16 bits, so 0A2h becomes FFA2h and `disp[15:8]` has no effect. When `disp_wide` = 1, all of `disp` is added unchanged.
- R5: Mode code 2 (based) gives `ea` = base + displacement. `base_sel` = 0 picks `reg_bx` with `seg_ds`, and `base_sel` = 1 picks `reg_bp` with `seg_ss`.
- R6: Mode code 3 (indexed) gives `ea` = index + displacement. `idx_sel` = 0 picks `reg_si` and `idx_sel` = 1 picks `reg_di`. The segment is always `seg_ds`.
- R7: Mode code 4 (based indexed) gives `ea` = base + index + displacement, with base and index picked as in R5 and R6. The segment is `seg_ss` when the base is `reg_bp` and `seg_ds` when the base is `reg_bx`.
- R8: Mode code 5 (IP relative) gives `ea` = `ip` + sign-extended `disp[7:0]`, whatever the value of `disp_wide`. The segment is `seg_cs`.
- R9: Mode code 6 (string destination) gives `ea` = `reg_di` with segment `seg_es`. `disp` is ignored.
- R10: The offset sum wraps modulo 65536. For example, BX FFFFh + SI 0002h + displacement 0001h gives `ea` 0002h.
- R11: Mode code 7 is reserved. It drives `ea` = 0 and `pa` = 0 and sets `mode_err` = 1. Every other code leaves `mode_err` = 0.
- R12: With `REG_OUT` = 1, outputs reflect the inputs present at the previous rising edge of `clk`. While `rst_n` is low, `ea`, `pa` and `mode_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Addressing mode code (0..7) |
| ptr_sel | input | 2 | Pointer choice for register-indirect mode |
| base_sel | input | 1 | Base choice: 0 = BX, 1 = BP |
| idx_sel | input | 1 | Index choice: 0 = SI, 1 = DI |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = sign-extended low byte |
| disp | input | OFS_W | Displacement or direct offset from the instruction |
| seg_cs | input | SEG_W | Code segment value |
| seg_ds | input | SEG_W | Data segment value |
| seg_ss | input | SEG_W | Stack segment value |
| seg_es | input | SEG_W | Extra segment value |
| reg_bx | input | OFS_W | Base register BX |
| reg_bp | input | OFS_W | Base register BP |
| reg_si | input | OFS_W | Index register SI |
| reg_di | input | OFS_W | Index register DI |
| ip | input | OFS_W | Instruction pointer |
| ea | output | OFS_W | Effective (offset) address |
| pa | output | SEG_W+SHIFT | Physical address |
| mode_err | output | 1 | Reserved mode code seen |

## Verification
The corners that are hardest to reach are the wrap cases, where either the three-term offset sum or the shifted-segment sum carries out of its width. Uniform random register values rarely land near the top of both ranges at once. Directed vectors place BX at FFFFh and a segment at FFFFh to force both carries. The displacement corners are also hard to reach by chance: garbage in `disp[15:8]` while in short mode, and a wide request in IP-relative mode that must still use only the low byte. These are covered by directed vectors, while seeded random vectors sweep all eight mode codes with every select combination.

// File: rtl/sag_pkg.sv
package sag_pkg;

    // Addressing mode codes; code order is fixed by the decoder that drives them.
    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_REG_IND  = 3'd1,
        AM_BASED    = 3'd2,
        AM_INDEXED  = 3'd3,
        AM_BASE_IDX = 3'd4,
        AM_IP_REL   = 3'd5,
        AM_STR_DST  = 3'd6,
        AM_RSVD     = 3'd7
    } amode_e;

    // Which segment register supplies the paragraph base.
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } segsel_e;

endpackage

// File: rtl/sag_disp_ext.sv
module sag_disp_ext #(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [OFS_W-1:0] disp,
    input  logic             wide,
    output logic [OFS_W-1:0] ext_sel,
    output logic [OFS_W-1:0] ext_short
);
    localparam int PAD_W = OFS_W - SHORT_W;

    // Short form: low byte sign-extended, upper bits discarded.
    assign ext_short = {{PAD_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    // Width-selected form used by the register-relative modes.
    assign ext_sel   = wide ? disp : ext_short;

endmodule

// File: rtl/sag_offset_calc.sv
module sag_offset_calc
    import sag_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  amode_e           am,
    input  logic [1:0]       ptr_sel,
    input  logic             base_sel,
    input  logic             idx_sel,
    input  logic [OFS_W-1:0] disp_raw,
    input  logic [OFS_W-1:0] disp_sel,
    input  logic [OFS_W-1:0] disp_short,
    input  logic [OFS_W-1:0] reg_bx,
    input  logic [OFS_W-1:0] reg_bp,
    input  logic [OFS_W-1:0] reg_si,
    input  logic [OFS_W-1:0] reg_di,
    input  logic [OFS_W-1:0] ip,
    output logic [OFS_W-1:0] ea,
    output segsel_e          seg_sel,
    output logic             valid
);
    logic [OFS_W-1:0] base_v;
    logic [OFS_W-1:0] idx_v;
    logic [OFS_W-1:0] ptr_v;
    segsel_e          base_seg;

    always_comb begin
        base_v   = base_sel ? reg_bp : reg_bx;
        base_seg = base_sel ? SEG_STACK : SEG_DATA;
        idx_v    = idx_sel ? reg_di : reg_si;
        unique case (ptr_sel)
            2'd0:    ptr_v = reg_bx;
            2'd1:    ptr_v = reg_bp;
            2'd2:    ptr_v = reg_si;
            default: ptr_v = reg_di;
        endcase
    end

    // Sums are kept at OFS_W bits so carries out of the offset are dropped.
    always_comb begin
        ea      = '0;
        seg_sel = SEG_DATA;
        valid   = 1'b1;
        unique case (am)
            AM_DIRECT: begin
                ea      = disp_raw;
                seg_sel = SEG_DATA;
            end
            AM_REG_IND: begin
                ea      = ptr_v;
                seg_sel = SEG_DATA;
            end
            AM_BASED: begin
                ea      = base_v + disp_sel;
                seg_sel = base_seg;
            end
            AM_INDEXED: begin
                ea      = idx_v + disp_sel;
                seg_sel = SEG_DATA;
            end
            AM_BASE_IDX: begin
                ea      = base_v + idx_v + disp_sel;
                seg_sel = base_seg;
            end
            AM_IP_REL: begin
                ea      = ip + disp_short;
                seg_sel = SEG_CODE;
            end
            AM_STR_DST: begin
                ea      = reg_di;
                seg_sel = SEG_EXTRA;
            end
            AM_RSVD: begin
                ea      = '0;
                seg_sel = SEG_DATA;
                valid   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sag_phys_add.sv
module sag_phys_add #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg,
    input  logic [OFS_W-1:0]       ofs,
    output logic [SEG_W+SHIFT-1:0] pa
);
    localparam int PA_W  = SEG_W + SHIFT;
    localparam int ZPAD  = PA_W - OFS_W;

    logic [PA_W-1:0] seg_base;
    logic [PA_W-1:0] ofs_ext;

    assign seg_base = {seg, {SHIFT{1'b0}}};
    assign ofs_ext  = {{ZPAD{1'b0}}, ofs};
    // Carry out of PA_W is discarded: the address space wraps.
    assign pa       = seg_base + ofs_ext;

endmodule

// File: rtl/sag_addr_gen.sv
module sag_addr_gen
    import sag_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFS_W   = 16,
    parameter int SHIFT   = 4,
    parameter int SHORT_W = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode,
    input  logic [1:0]             ptr_sel,
    input  logic                   base_sel,
    input  logic                   idx_sel,
    input  logic                   disp_wide,
    input  logic [OFS_W-1:0]       disp,
    input  logic [SEG_W-1:0]       seg_cs,
    input  logic [SEG_W-1:0]       seg_ds,
    input  logic [SEG_W-1:0]       seg_ss,
    input  logic [SEG_W-1:0]       seg_es,
    input  logic [OFS_W-1:0]       reg_bx,
    input  logic [OFS_W-1:0]       reg_bp,
    input  logic [OFS_W-1:0]       reg_si,
    input  logic [OFS_W-1:0]       reg_di,
    input  logic [OFS_W-1:0]       ip,
    output logic [OFS_W-1:0]       ea,
    output logic [SEG_W+SHIFT-1:0] pa,
    output logic                   mode_err
);
    localparam int PA_W = SEG_W + SHIFT;

    amode_e           am;
    logic [OFS_W-1:0] dsp_sel;
    logic [OFS_W-1:0] dsp_short;
    logic [OFS_W-1:0] ea_c;
    segsel_e          ssel;
    logic             ok_c;
    logic [SEG_W-1:0] seg_c;
    logic [PA_W-1:0]  pa_raw;
    logic [OFS_W-1:0] ea_n;
    logic [PA_W-1:0]  pa_n;
    logic             err_n;

    assign am = amode_e'(mode);

    sag_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_dext (
        .disp      (disp),
        .wide      (disp_wide),
        .ext_sel   (dsp_sel),
        .ext_short (dsp_short)
    );

    sag_offset_calc #(.OFS_W(OFS_W)) u_ofs (
        .am         (am),
        .ptr_sel    (ptr_sel),
        .base_sel   (base_sel),
        .idx_sel    (idx_sel),
        .disp_raw   (disp),
        .disp_sel   (dsp_sel),
        .disp_short (dsp_short),
        .reg_bx     (reg_bx),
        .reg_bp     (reg_bp),
        .reg_si     (reg_si),
        .reg_di     (reg_di),
        .ip         (ip),
        .ea         (ea_c),
        .seg_sel    (ssel),
        .valid      (ok_c)
    );

    always_comb begin
        unique case (ssel)
            SEG_CODE:  seg_c = seg_cs;
            SEG_DATA:  seg_c = seg_ds;
            SEG_STACK: seg_c = seg_ss;
            SEG_EXTRA: seg_c = seg_es;
        endcase
    end

    sag_phys_add #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_pa (
        .seg (seg_c),
        .ofs (ea_c),
        .pa  (pa_raw)
    );

    // Reserved code forces both addresses to zero.
    assign ea_n  = ok_c ? ea_c   : '0;
    assign pa_n  = ok_c ? pa_raw : '0;
    assign err_n = ~ok_c;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ea       <= '0;
                    pa       <= '0;
                    mode_err <= 1'b0;
                end else begin
                    ea       <= ea_n;
                    pa       <= pa_n;
                    mode_err <= err_n;
                end
            end
        end else begin : g_comb
            assign ea       = ea_n;
            assign pa       = pa_n;
            assign mode_err = err_n;
        end
    endgenerate

endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
    parameter int SEG_W   = 16,
    parameter int OFS_W   = 16,
    parameter int SHIFT   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             mode,
    input logic                   base_sel,
    input logic [OFS_W-1:0]       disp,
    input logic [SEG_W-1:0]       seg_cs,
    input logic [SEG_W-1:0]       seg_ds,
    input logic [SEG_W-1:0]       seg_ss,
    input logic [SEG_W-1:0]       seg_es,
    input logic [OFS_W-1:0]       reg_di,
    input logic [OFS_W-1:0]       ea,
    input logic [SEG_W+SHIFT-1:0] pa,
    input logic                   mode_err
);
    localparam int PA_W = SEG_W + SHIFT;

    function automatic logic [PA_W-1:0] join_addr(input logic [SEG_W-1:0] s,
                                                  input logic [OFS_W-1:0] o);
        return {s, {SHIFT{1'b0}}} + PA_W'(o);
    endfunction

    logic [2:0]       mode_q;
    logic             base_q;
    logic [OFS_W-1:0] disp_q;
    logic [SEG_W-1:0] cs_q, ds_q, ss_q, es_q;
    logic [OFS_W-1:0] di_q;
    logic             primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            base_q <= 1'b0;
            disp_q <= '0;
            cs_q   <= '0;
            ds_q   <= '0;
            ss_q   <= '0;
            es_q   <= '0;
            di_q   <= '0;
            primed <= 1'b0;
        end else begin
            mode_q <= mode;
            base_q <= base_sel;
            disp_q <= disp;
            cs_q   <= seg_cs;
            ds_q   <= seg_ds;
            ss_q   <= seg_ss;
            es_q   <= seg_es;
            di_q   <= reg_di;
            primed <= 1'b1;
        end
    end

    logic [2:0]       o_mode;
    logic             o_base;
    logic [OFS_W-1:0] o_disp;
    logic [SEG_W-1:0] o_cs, o_ds, o_ss, o_es;
    logic [OFS_W-1:0] o_di;
    logic             o_ok;

    generate
        if (REG_OUT) begin : g_late
            assign o_mode = mode_q;
            assign o_base = base_q;
            assign o_disp = disp_q;
            assign o_cs   = cs_q;
            assign o_ds   = ds_q;
            assign o_ss   = ss_q;
            assign o_es   = es_q;
            assign o_di   = di_q;
            assign o_ok   = primed;

            // R12: outputs held at zero during reset
            p_reset_clear_r12: assert property (@(posedge clk)
                !rst_n |-> (ea == '0 && pa == '0 && !mode_err));
        end else begin : g_live
            assign o_mode = mode;
            assign o_base = base_sel;
            assign o_disp = disp;
            assign o_cs   = seg_cs;
            assign o_ds   = seg_ds;
            assign o_ss   = seg_ss;
            assign o_es   = seg_es;
            assign o_di   = reg_di;
            assign o_ok   = 1'b1;
        end
    endgenerate

    p_direct_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode == 3'd0) |-> (ea == o_disp && pa == join_addr(o_ds, ea)));

    p_regind_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode == 3'd1) |-> (pa == join_addr(o_ds, ea)));

    p_bidx_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode == 3'd4 && o_base) |-> (pa == join_addr(o_ss, ea)));

    p_iprel_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode == 3'd5) |-> (pa == join_addr(o_cs, ea)));

    p_strdst_es_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode == 3'd6) |-> (ea == o_di && pa == join_addr(o_es, ea)));

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode == 3'd7) |-> (mode_err && ea == '0 && pa == '0));

    p_err_only_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ok && o_mode != 3'd7) |-> !mode_err);

endmodule

bind sag_addr_gen sag_chk #(
    .SEG_W   (SEG_W),
    .OFS_W   (OFS_W),
    .SHIFT   (SHIFT),
    .REG_OUT (REG_OUT)
) u_chk (.*);

// File: tb/sag_addr_gen_tb.sv
module sag_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic        base_sel = 1'b0;
    logic        idx_sel = 1'b0;
    logic        disp_wide = 1'b0;
    logic [15:0] disp = '0;
    logic [15:0] seg_cs = '0, seg_ds = '0, seg_ss = '0, seg_es = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, ip = '0;
    logic [15:0] ea;
    logic [19:0] pa;
    logic        mode_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] e_ea;
    logic [19:0] e_pa;
    logic        e_err;

    always #10 clk = ~clk;

    sag_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ptr_sel(ptr_sel),
        .base_sel(base_sel), .idx_sel(idx_sel), .disp_wide(disp_wide),
        .disp(disp), .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss),
        .seg_es(seg_es), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
        .reg_di(reg_di), .ip(ip), .ea(ea), .pa(pa), .mode_err(mode_err)
    );

    function automatic logic [15:0] sx8(input logic [15:0] d);
        return {{8{d[7]}}, d[7:0]};
    endfunction

    // Reference model written from the requirement list.
    task automatic predict();
        logic [15:0] dd, b, x, off;
        logic [15:0] sg;
        logic [19:0] full;
        dd  = disp_wide ? disp : sx8(disp);
        b   = base_sel ? reg_bp : reg_bx;
        x   = idx_sel ? reg_di : reg_si;
        off = '0;
        sg  = seg_ds;
        e_err = 1'b0;
        case (mode)
            3'd0: begin off = disp; sg = seg_ds; end
            3'd1: begin
                case (ptr_sel)
                    2'd0: off = reg_bx;
                    2'd1: off = reg_bp;
                    2'd2: off = reg_si;
                    default: off = reg_di;
                endcase
                sg = seg_ds;
            end
            3'd2: begin off = b + dd; sg = base_sel ? seg_ss : seg_ds; end
            3'd3: begin off = x + dd; sg = seg_ds; end
            3'd4: begin off = b + x + dd; sg = base_sel ? seg_ss : seg_ds; end
            3'd5: begin off = ip + sx8(disp); sg = seg_cs; end
            3'd6: begin off = reg_di; sg = seg_es; end
            default: e_err = 1'b1;
        endcase
        full = ({4'h0, sg} << 4) + {4'h0, off};
        e_ea = e_err ? 16'h0 : off;
        e_pa = e_err ? 20'h0 : full;
    endtask

    task automatic check(input string tag);
        n_tests++;
        if (ea !== e_ea || pa !== e_pa || mode_err !== e_err) begin
            n_fail++;
            $display("FAIL %s: ea=%h pa=%h err=%b expected ea=%h pa=%h err=%b",
                     tag, ea, pa, mode_err, e_ea, e_pa, e_err);
        end
    endtask

    // Called right after inputs change at a falling edge.
    task automatic go(input string tag);
        predict();
        @(posedge clk);
        #2;
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R12: reset state
        repeat (3) @(negedge clk);
        e_ea = '0; e_pa = '0; e_err = 1'b0;
        check("R12 reset");
        rst_n = 1'b1;

        // R1: worked example 89AB:F012 -> 98AC2
        @(negedge clk);
        mode = 3'd0; seg_ds = 16'h89AB; disp = 16'hF012; disp_wide = 1'b1;
        go("R1 example");
        n_tests++;
        if (pa !== 20'h98AC2) begin
            n_fail++;
            $display("FAIL R1 literal: pa=%h expected=98ac2", pa);
        end

        // R1: physical wrap FFFF:FFFF
        @(negedge clk);
        seg_ds = 16'hFFFF; disp = 16'hFFFF;
        go("R1 wrap");

        // R2: direct ignores disp_wide
        @(negedge clk);
        seg_ds = 16'h1000; disp = 16'h1280; disp_wide = 1'b0;
        go("R2 direct short flag");

        // R3: each pointer, BP still with DS
        @(negedge clk);
        mode = 3'd1; reg_bx = 16'h0111; reg_bp = 16'h0222; reg_si = 16'h0333;
        reg_di = 16'h0444; seg_ss = 16'h5000; seg_ds = 16'h2000;
        for (int k = 0; k < 4; k++) begin
            if (k != 0) @(negedge clk);
            ptr_sel = 2'(k);
            go("R3 pointer");
        end

        // R4: sign extension and ignored upper bits
        @(negedge clk);
        mode = 3'd3; idx_sel = 1'b0; reg_si = 16'h0000; disp = 16'h00A2; disp_wide = 1'b0;
        go("R4 sext A2");
        n_tests++;
        if (ea !== 16'hFFA2) begin
            n_fail++;
            $display("FAIL R4 literal: ea=%h expected=ffa2", ea);
        end
        @(negedge clk);
        disp = 16'h7FA2;
        go("R4 upper ignored");
        @(negedge clk);
        disp = 16'h00A2; disp_wide = 1'b1;
        go("R4 wide");

        // R5: based with BX and BP
        @(negedge clk);
        mode = 3'd2; base_sel = 1'b0; reg_bx = 16'h1234; disp = 16'h0008; disp_wide = 1'b0;
        go("R5 bx");
        @(negedge clk);
        base_sel = 1'b1; reg_bp = 16'h4321; disp = 16'h0090;
        go("R5 bp");

        // R6: indexed via DI
        @(negedge clk);
        mode = 3'd3; idx_sel = 1'b1; reg_di = 16'h0F00; disp = 16'h1111; disp_wide = 1'b1;
        go("R6 di");

        // R7: based indexed, both bases
        @(negedge clk);
        mode = 3'd4; base_sel = 1'b1; idx_sel = 1'b0; reg_si = 16'h0040; disp = 16'h000A;
        go("R7 bp si");
        @(negedge clk);
        base_sel = 1'b0; idx_sel = 1'b1;
        go("R7 bx di");

        // R8: IP relative always short
        @(negedge clk);
        mode = 3'd5; seg_cs = 16'hF000; ip = 16'h0100; disp = 16'h12F0; disp_wide = 1'b1;
        go("R8 ip rel");

        // R9: string destination ignores disp
        @(negedge clk);
        mode = 3'd6; seg_es = 16'h3000; reg_di = 16'h0010; disp = 16'hBEEF;
        go("R9 es di");

        // R10: offset wrap
        @(negedge clk);
        mode = 3'd4; base_sel = 1'b0; idx_sel = 1'b0; reg_bx = 16'hFFFF;
        reg_si = 16'h0002; disp = 16'h0001; disp_wide = 1'b1;
        go("R10 wrap");

        // R11: reserved code
        @(negedge clk);
        mode = 3'd7;
        go("R11 reserved");

        // R12: one-cycle latency, old value still present before the edge
        @(negedge clk);
        mode = 3'd6; reg_di = 16'h0777;
        #2;
        check("R12 hold");
        go("R12 update");

        // Seeded random sweep across all codes
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            mode = 3'($urandom); ptr_sel = 2'($urandom);
            base_sel = 1'($urandom); idx_sel = 1'($urandom);
            disp_wide = 1'($urandom); disp = 16'($urandom);
            seg_cs = 16'($urandom); seg_ds = 16'($urandom);
            seg_ss = 16'($urandom); seg_es = 16'($urandom);
            reg_bx = 16'($urandom); reg_bp = 16'($urandom);
            reg_si = 16'($urandom); reg_di = 16'($urandom); ip = 16'($urandom);
            go("random mix R1 R11");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule